// File: doc/BRIEF.md
# Corner-Turn Reorder Buffer

This block takes a multichannel sample stream that arrives time-interleaved, one sample per clock, and re-emits it channel-major. In the input, every channel's sample for time step 1 comes first, then every channel's sample for time step 2, and so on. A block holds `BLK_T` time steps of `NUM_CH` channels. On the output side the block sends every time step of channel 0, then every time step of channel 1, up to the last channel. The output feeds a DMA sink that wants each channel's samples contiguous.

Storage is one simple dual-port RAM holding two pages. A page bit sits at the top of the address. The writer fills one page while the reader drains the other, which was completed earlier. The page bit flips each time a full block has been accepted. At that moment the reader is launched on the page just filled, so a block is never read while it is partly written.

The writer places each sample at `t*NUM_CH + ch` by stepping a linear offset. The reader forms the transposed address from counters alone, with no multiplier. A configurable read pipeline of `RD_LAT` registers (2 or 3) lets the RAM close timing at high clock rates. The output valid is delayed by the same amount.

Top module: `cturn_reorder`

## Requirements
- R1: A synchronous reset held for one or more clocks clears the write offset, the page bit and the reader, and `out_valid` is low in the first cycle after reset is released.
- R2: `out_valid` stays low until `NUM_CH*BLK_T` input samples have been accepted since reset.
- R3: Within a block, input sample number `t*NUM_CH + ch` (time `t`, channel `ch`, both from 0) leaves as output number `ch*BLK_T + t`: time index fastest, channel slowest.
- R4: Suppose the last sample of a block is accepted on clock edge E. The first output of that block is then valid right after edge E+`RD_LAT`.
- R5: A block's `NUM_CH*BLK_T` outputs leave on consecutive cycles. When input arrives every cycle, the next block's outputs follow with no idle cycle, giving one sample in and one sample out per clock.
- R6: A cycle with `in_valid` low writes nothing and leaves the write offset and page unchanged. A block is complete only after its full count of valid samples.
- R7: The reader always uses the page opposite the one being written. Writing the next block never alters the block being read out.
- R8: A partly written block that is followed by reset is discarded. The next block after reset starts at offset 0 and is emitted in full and correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DW | Input sample, time-interleaved order |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | DW | Output sample, channel-major order |

## Verification
The scoreboard predicts every output sample together with the exact cycle it must appear. This catches several kinds of bug:
- A reader whose counters step in the wrong order produces mismatched data.
- A valid pipeline that is off by one stage is flagged on the first sample of each block.
- A reader that reads the page being written corrupts the back-to-back blocks.
- A writer that advances on idle cycles finishes gapped blocks early, which shifts both the data and the timing.

A partly written block followed by reset exposes counters that survive reset: the following block would complete early and come out scrambled.

// File: rtl/cturn_pkg.sv
package cturn_pkg;
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/cturn_wr_ctrl.sv
module cturn_wr_ctrl #(
    parameter int NUM_CH = 16,
    parameter int BLK_T  = 10,
    localparam int BLK_N = NUM_CH * BLK_T,
    localparam int OW    = $clog2(BLK_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic [OW-1:0] wr_off,
    output logic          wr_page,
    output logic          blk_done
);
    typedef struct packed {
        logic          page;
        logic [OW-1:0] off;
    } wr_st_t;

    wr_st_t st_d, st_q;

    assign blk_done = in_valid && (st_q.off == OW'(BLK_N - 1));
    assign wr_off   = st_q.off;
    assign wr_page  = st_q.page;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (blk_done) begin
                st_d.off  = '0;
                st_d.page = ~st_q.page;
            end else begin
                st_d.off = st_q.off + OW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/cturn_rd_ctrl.sv
module cturn_rd_ctrl
    import cturn_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int BLK_T  = 10,
    localparam int BLK_N = NUM_CH * BLK_T,
    localparam int OW    = $clog2(BLK_N),
    localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int TW    = (BLK_T > 1) ? $clog2(BLK_T) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_done,
    input  logic          wr_page,
    output logic [OW:0]   rd_addr,
    output logic          rd_active,
    output logic          rd_last,
    output logic          rd_page
);
    typedef struct packed {
        rd_mode_e      mode;
        logic          page;
        logic [CW-1:0] ch;
        logic [TW-1:0] t;
        logic [OW-1:0] off;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic t_wrap;

    assign t_wrap    = (st_q.t == TW'(BLK_T - 1));
    assign rd_active = (st_q.mode == RD_RUN);
    assign rd_last   = rd_active && t_wrap && (st_q.ch == CW'(NUM_CH - 1));
    assign rd_page   = st_q.page;
    assign rd_addr   = {st_q.page, st_q.off};

    always_comb begin
        st_d = st_q;
        if (blk_done) begin
            // launch on the page that is completing this cycle
            st_d.mode = RD_RUN;
            st_d.page = wr_page;
            st_d.ch   = '0;
            st_d.t    = '0;
            st_d.off  = '0;
        end else if (rd_active) begin
            if (rd_last) begin
                st_d.mode = RD_IDLE;
            end else if (t_wrap) begin
                st_d.t   = '0;
                st_d.ch  = st_q.ch + CW'(1);
                st_d.off = OW'(st_q.ch) + OW'(1);
            end else begin
                st_d.t   = st_q.t + TW'(1);
                st_d.off = st_q.off + OW'(NUM_CH);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: RD_IDLE, default: '0};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/cturn_ram.sv
module cturn_ram #(
    parameter int DW     = 32,
    parameter int AW     = 9,
    parameter int RD_LAT = 2,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] pipe [RD_LAT];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        pipe[0] <= mem[raddr];
    end

    for (genvar g = 1; g < RD_LAT; g++) begin : g_rd_stage
        always_ff @(posedge clk) begin
            pipe[g] <= pipe[g-1];
        end
    end

    assign rdata = pipe[RD_LAT-1];
endmodule

// File: rtl/cturn_reorder.sv
module cturn_reorder #(
    parameter int DW     = 32,
    parameter int NUM_CH = 16,
    parameter int BLK_T  = 10,
    parameter int RD_LAT = 2,
    localparam int BLK_N = NUM_CH * BLK_T,
    localparam int OW    = $clog2(BLK_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic [RD_LAT-1:0] vld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [OW-1:0] wr_off;
    logic          wr_page;
    logic          blk_done;
    logic [OW:0]   rd_addr;
    logic          rd_active;
    logic          rd_last;
    logic          rd_page;

    cturn_wr_ctrl #(.NUM_CH(NUM_CH), .BLK_T(BLK_T)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .wr_off   (wr_off),
        .wr_page  (wr_page),
        .blk_done (blk_done)
    );

    cturn_rd_ctrl #(.NUM_CH(NUM_CH), .BLK_T(BLK_T)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .blk_done  (blk_done),
        .wr_page   (wr_page),
        .rd_addr   (rd_addr),
        .rd_active (rd_active),
        .rd_last   (rd_last),
        .rd_page   (rd_page)
    );

    cturn_ram #(.DW(DW), .AW(OW + 1), .RD_LAT(RD_LAT)) u_ram (
        .clk   (clk),
        .we    (in_valid),
        .waddr ({wr_page, wr_off}),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (out_data)
    );

    always_comb begin
        st_d = st_q;
        if (RD_LAT > 1) st_d.vld = {st_q.vld[RD_LAT-2:0], rd_active};
        else            st_d.vld = rd_active;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld[RD_LAT-1];
endmodule

// File: rtl/cturn_reorder_chk.sv
module cturn_reorder_chk #(
    parameter int NUM_CH = 16,
    parameter int BLK_T  = 10,
    parameter int RD_LAT = 2,
    localparam int BLK_N = NUM_CH * BLK_T,
    localparam int OW    = $clog2(BLK_N)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [OW-1:0] wr_off,
    input logic          wr_page,
    input logic          blk_done,
    input logic          rd_active,
    input logic          rd_last,
    input logic          rd_page
);
    logic [OW-1:0] seen_cnt_q;
    logic          full_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_cnt_q  <= '0;
            full_seen_q <= 1'b0;
        end else if (in_valid) begin
            if (seen_cnt_q == OW'(BLK_N - 1)) begin
                seen_cnt_q  <= '0;
                full_seen_q <= 1'b1;
            end else begin
                seen_cnt_q <= seen_cnt_q + OW'(1);
            end
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    assert_no_early_output_R2: assert property (@(posedge clk) disable iff (rst)
        !full_seen_q |-> !out_valid);

    assert_valid_tracks_read_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rd_active, RD_LAT));

    assert_no_read_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> (!rd_active || rd_last));

    assert_idle_holds_writer_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(wr_off) && $stable(wr_page)));

    assert_read_opposite_page_R7: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> (rd_page != wr_page));
endmodule

bind cturn_reorder cturn_reorder_chk #(
    .NUM_CH (NUM_CH),
    .BLK_T  (BLK_T),
    .RD_LAT (RD_LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .wr_off    (wr_off),
    .wr_page   (wr_page),
    .blk_done  (blk_done),
    .rd_active (rd_active),
    .rd_last   (rd_last),
    .rd_page   (rd_page)
);

// File: tb/cturn_reorder_tb.sv
module cturn_reorder_tb;
    localparam int DW     = 32;
    localparam int NUM_CH = 16;
    localparam int BLK_T  = 10;
    localparam int RD_LAT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    cturn_reorder #(.DW(DW), .NUM_CH(NUM_CH), .BLK_T(BLK_T), .RD_LAT(RD_LAT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [DW-1:0] d;
        int            at;
        int            ch;
        int            t;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   ended  = 1'b0;

    function automatic logic [DW-1:0] mk(int blk, int t, int ch);
        return {8'(blk), 8'(t), 8'(ch), 8'h5A} ^ DW'(blk * 7919);
    endfunction

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check_idle(string req);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s out_valid actual=%b expected=0", req, out_valid);
        end
    endtask

    // Driver: input sample (t,ch) goes out as number ch*BLK_T+t (R3), the first one
    // RD_LAT edges after the last write edge (R4), the rest on consecutive cycles (R5).
    task automatic send_block(int blk, bit gaps, bit record, int count);
        int n = 0;
        for (int t = 0; t < BLK_T; t++) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (n < count) begin
                    if (gaps && ((t + ch + blk) % 4 == 0)) begin
                        @(negedge clk);
                        in_valid = 1'b0;   // R6: idle cycle inside a block
                    end
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_data  = mk(blk, t, ch);
                    n++;
                    if (record && t == BLK_T - 1 && ch == NUM_CH - 1) begin
                        for (int c = 0; c < NUM_CH; c++) begin
                            for (int tt = 0; tt < BLK_T; tt++) begin
                                exp_q.push_back('{d: mk(blk, tt, c),
                                                  at: cyc + 1 + RD_LAT + c * BLK_T + tt,
                                                  ch: c, t: tt});
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic go_idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        go_idle(4);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && out_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2 unexpected output actual=%h expected=no output", out_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (out_data !== e.d) begin   // R3 order, R7 page isolation
                    fails++;
                    $display("FAIL R3 ch=%0d t=%0d data actual=%h expected=%h",
                             e.ch, e.t, out_data, e.d);
                end
                checks++;
                if (cyc != e.at) begin
                    fails++;
                    if (e.ch == 0 && e.t == 0)
                        $display("FAIL R4 first output cycle actual=%0d expected=%0d", cyc, e.at);
                    else
                        $display("FAIL R5 output cycle ch=%0d t=%0d actual=%0d expected=%0d",
                                 e.ch, e.t, cyc, e.at);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_idle("R1");
        end
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        // R2, R3, R5, R7: continuous back-to-back blocks
        send_block(0, 1'b0, 1'b1, NUM_CH * BLK_T);
        send_block(1, 1'b0, 1'b1, NUM_CH * BLK_T);
        send_block(2, 1'b0, 1'b1, NUM_CH * BLK_T);
        // R6: gapped input
        send_block(3, 1'b1, 1'b1, NUM_CH * BLK_T);
        send_block(4, 1'b1, 1'b1, NUM_CH * BLK_T);
        go_idle(20);
        send_block(5, 1'b0, 1'b1, NUM_CH * BLK_T);
        go_idle(1);
        drain();

        // R8: partial block then reset
        send_block(6, 1'b0, 1'b0, 100);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_idle("R8");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        send_block(7, 1'b0, 1'b1, NUM_CH * BLK_T);
        go_idle(1);
        drain();

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R5 missing outputs actual=%0d pending expected=0", exp_q.size());
        end
        finish_up();
    end
endmodule